// File: doc/BRIEF.md
# Token-Chained Depth-Expandable FIFO

This block builds one deep first-in/first-out queue out of several identical shallow slices joined in a ring. Each slice has its own small memory, its own read and write pointers and its own full and empty flags. It stores words only while it owns the write token, and it returns words only while it owns the read token. When a slice writes into its last physical location, a one-cycle write-handoff pulse on its expansion output passes the write token to the next slice in the ring. When it reads its last location, a separate read-handoff pulse passes the read token on in the same way. Both pulses may fire in the same cycle.

A first-load input on each slice picks the one slice that holds both tokens after reset. The wrapper ties this input low for slice 0 and high for all other slices. The wrapper combines the active-low flags of all slices into composite flags. Composite full asserts only when every slice is full, and composite empty asserts only when every slice is empty. Read data comes from the single slice that performed the read and passes through a one-hot multiplexer. From the outside, SLICES slices of SLICE_DEPTH words each behave like one synchronous FIFO holding SLICES*SLICE_DEPTH words. The block has no retransmit and no half-full indication.

Top module: `depth_chain_fifo`

## Requirements
- R1: While `rstN` is low, and after it rises, `emptyN` is 0, `fullN` is 1 and `rdValid` is 0.
- R2: A rising clock edge with `wrEn`=1 and `fullN`=1 stores `wrData`.
- R3: The capacity is exactly SLICES*SLICE_DEPTH words. `fullN` is 0 exactly when that many words are held.
- R4: A write attempted while `fullN` is 0 is dropped. The stored contents and their order stay unchanged, which shows in the data read out later.
- R5: A read attempted while `emptyN` is 0 has no effect. `rdValid` stays 0 in the following cycle.
- R6: A read accepted at an edge (`rdEn`=1 with `emptyN`=1) presents the oldest stored word on `rdData` with `rdValid`=1 after that edge. Order is kept across slice boundaries and around the ring.
- R7: Simultaneous read and write are both accepted when neither flag blocks them. When full, only the read is accepted. When empty, only the write is accepted.
- R8: At every cycle exactly one slice holds the write token and exactly one holds the read token. After reset both tokens sit in slice 0, whose first-load input is low. A slice that writes (or reads) its last location hands that token on with a one-cycle pulse, and its pointer returns to location 0.
- R9: `emptyN` is the OR of the per-slice active-low empty flags and `fullN` the OR of the active-low full flags. After an accepted write, `emptyN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrData | input | WIDTH | Word to store |
| fullN | output | 1 | Composite full flag, active low |
| rdEn | input | 1 | Read request |
| rdData | output | WIDTH | Word returned by the previous accepted read |
| rdValid | output | 1 | High for one cycle after an accepted read |
| emptyN | output | 1 | Composite empty flag, active low |

## Verification
The bench builds the block with three slices of four words each and a 9-bit data path, for a total capacity of twelve. At this size a few hundred operations carry both tokens around the ring many times. Every full, empty and wrap-around boundary, including simultaneous handoffs of both tokens, is reached again and again. A queue model in the bench predicts each flag and each returned word arithmetically from the counts of accepted operations. Directed phases cover filling, overflow, draining, underflow and simultaneous traffic. A long pseudo-random run then mixes all of these.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // strobes the slice control hands to the slice datapath each cycle
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } slice_strobe_t;
endpackage

// File: rtl/chain_slice_ctrl.sv
module chain_slice_ctrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 firstLoadN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic                 xiWr,
  input  logic                 xiRd,
  output slice_strobe_t        strobe,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic                 xoWr,
  output logic                 xoRd,
  output logic                 sliceFullN,
  output logic                 sliceEmptyN,
  output logic                 wrTok,
  output logic                 rdTok
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  assign sliceFullN     = (count != FULL_CNT);
  assign sliceEmptyN    = (count != '0);
  assign strobe.doWrite = wrEn & wrTok & sliceFullN;
  assign strobe.doRead  = rdEn & rdTok & sliceEmptyN;
  assign xoWr   = strobe.doWrite & (wrPtr == LAST_LOC);
  assign xoRd   = strobe.doRead  & (rdPtr == LAST_LOC);
  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      wrTok <= ~firstLoadN;
      rdTok <= ~firstLoadN;
    end else begin
      if (strobe.doWrite) wrPtr <= xoWr ? '0 : wrPtr + 1'b1;
      if (strobe.doRead)  rdPtr <= xoRd ? '0 : rdPtr + 1'b1;
      case ({strobe.doWrite, strobe.doRead})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      wrTok <= (wrTok & ~xoWr) | xiWr;
      rdTok <= (rdTok & ~xoRd) | xiRd;
    end
  end

  // R8
  wr_handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    xoWr |=> (wrPtr == '0));
  // R8
  rd_handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    xoRd |=> (rdPtr == '0));
  // R3
  slice_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
endmodule

// File: rtl/chain_slice_data.sv
module chain_slice_data
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slice_strobe_t            strobe,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [WIDTH-1:0]         wrData,
  output logic [WIDTH-1:0]         rdData,
  output logic                     rdValid
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.doWrite) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.doRead;
      if (strobe.doRead) rdData <= mem[rdAddr];
    end
  end
endmodule

// File: rtl/chain_slice.sv
module chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             firstLoadN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic             xiWr,
  input  logic             xiRd,
  output logic             xoWr,
  output logic             xoRd,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             sliceFullN,
  output logic             sliceEmptyN,
  output logic             wrTok,
  output logic             rdTok
);
  localparam int AW = $clog2(DEPTH);

  slice_strobe_t strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  chain_slice_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN),
    .wrEn(wrEn), .rdEn(rdEn), .xiWr(xiWr), .xiRd(xiRd),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .xoWr(xoWr), .xoRd(xoRd),
    .sliceFullN(sliceFullN), .sliceEmptyN(sliceEmptyN),
    .wrTok(wrTok), .rdTok(rdTok)
  );

  chain_slice_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/depth_chain_fifo.sv
module depth_chain_fifo #(
  parameter int SLICES      = 3,
  parameter int SLICE_DEPTH = 4,
  parameter int WIDTH       = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             fullN,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             emptyN
);
  logic [SLICES-1:0] xoWr, xoRd, validVec, fullVecN, emptyVecN, wrTokVec, rdTokVec;
  logic [WIDTH-1:0]  sliceData [SLICES];

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = (i + SLICES - 1) % SLICES;
    chain_slice #(.DEPTH(SLICE_DEPTH), .WIDTH(WIDTH)) u_slice (
      .clk(clk), .rstN(rstN),
      .firstLoadN((i == 0) ? 1'b0 : 1'b1),
      .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
      .xiWr(xoWr[PREV]), .xiRd(xoRd[PREV]),
      .xoWr(xoWr[i]), .xoRd(xoRd[i]),
      .rdData(sliceData[i]), .rdValid(validVec[i]),
      .sliceFullN(fullVecN[i]), .sliceEmptyN(emptyVecN[i]),
      .wrTok(wrTokVec[i]), .rdTok(rdTokVec[i])
    );
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < SLICES; i++)
      rdData = rdData | (sliceData[i] & {WIDTH{validVec[i]}});
  end

  assign rdValid = |validVec;
  assign fullN   = |fullVecN;
  assign emptyN  = |emptyVecN;

  // R8
  wr_token_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrTokVec) == 1);
  // R8
  rd_token_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rdTokVec) == 1);
  // R6
  one_reader_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(validVec));
  // R9
  write_unempties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fullN) |=> emptyN);
  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !emptyN |=> !rdValid);
endmodule

// File: tb/tb_depth_chain_fifo.sv
module tb_depth_chain_fifo;
  localparam int SLICES = 3;
  localparam int SDEPTH = 4;
  localparam int WIDTH  = 9;
  localparam int CAP    = SLICES * SDEPTH;

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0;
  logic [WIDTH-1:0] wrData = '0, rdData;
  logic fullN, emptyN, rdValid;

  int testsRun = 0, testsFailed = 0;
  logic [WIDTH-1:0] model [$];
  logic [WIDTH-1:0] nextVal = 9'd1;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  depth_chain_fifo #(.SLICES(SLICES), .SLICE_DEPTH(SDEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .fullN(fullN),
    .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid), .emptyN(emptyN)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at the next negedge
  task automatic step(input logic w, input logic r, input string tag);
    bit wAcc, rAcc;
    logic [WIDTH-1:0] expData;
    wAcc = w && (model.size() < CAP);
    rAcc = r && (model.size() > 0);
    expData = '0;
    wrEn = w; rdEn = r; wrData = nextVal;
    if (rAcc) expData = model.pop_front();
    if (wAcc) begin model.push_back(nextVal); nextVal = nextVal + 9'd7; end
    @(negedge clk);
    chk(rdValid == rAcc, rAcc ? tag : "R5", "rdValid", int'(rdValid), int'(rAcc));
    if (rAcc) chk(rdData == expData, tag, "rdData (R6 order)", int'(rdData), int'(expData));
    chk(fullN == (model.size() != CAP), "R3", "fullN", int'(fullN), int'(model.size() != CAP));
    chk(emptyN == (model.size() != 0), "R9", "emptyN", int'(emptyN), int'(model.size() != 0));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    // R1 during reset
    chk(emptyN == 1'b0, "R1", "emptyN in reset", int'(emptyN), 0);
    chk(fullN == 1'b1, "R1", "fullN in reset", int'(fullN), 1);
    chk(rdValid == 1'b0, "R1", "rdValid in reset", int'(rdValid), 0);
    rstN = 1;
    @(negedge clk);
    chk(emptyN == 1'b0 && fullN == 1'b1 && rdValid == 1'b0, "R1", "flags after reset",
        int'({emptyN, fullN, rdValid}), 3'b010);

    // R2 fill through every slice, R4 extra writes while full
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R4");
    // R4 drain: order must show dropped writes left no trace; R5 underflow
    for (int i = 0; i < CAP; i++) step(1'b0, 1'b1, "R4");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R5");

    // R7 simultaneous traffic at empty, mid level and full
    step(1'b1, 1'b1, "R7");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R7");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, "R7");
    while (model.size() < CAP) step(1'b1, 1'b0, "R7");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R7");
    while (model.size() > 0) step(1'b0, 1'b1, "R7");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R7");

    // R8 long mixed run: tokens wrap the ring many times
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], "R8");
    end
    while (model.size() > 0) step(1'b0, 1'b1, "R8");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule